// File: doc/BRIEF.md
# Timer Channel Trigger Generator

This block watches a free-running PWM timer counter and produces a one-cycle trigger pulse whenever the counter equals the compare value of an enabled channel. A second source can also fire it: the counter reaching its initial (reload) value. Only channels 0 to 5 may produce triggers. Compare inputs for channels 6 and 7 are present but never take part. Several channels may be enabled together, so one PWM period can hold several triggers.

A single 32-bit control/status word holds the per-channel enables, the initial-value trigger enable and a sticky flag that records that a trigger happened. Software clears the flag in two steps. First it reads the word while the flag is set, which arms the clear. Then it writes a 0 into the flag bit. A trigger that lands between the two steps cancels the clear. The counter, the initial value and the compare values come from outside, and the register port has no address because it holds one word.

The trigger output is registered. A match that is present during one clock cycle shows up as `trig_o` high during the next cycle. Read data is combinational from the current register state.

Top module: `trig_chan_gen`

## Requirements
- R1: When channel c (0 to 5) is enabled and `cmp_val_i` slice c equals `cnt_i` during a cycle, `trig_o` is high for the following cycle only. Slice c is bits [16c+15:16c].
- R2: Equality of `cnt_i` with the compare value of channel 6 or 7 never raises `trig_o` and never sets the flag, even when every enable bit is written to 1.
- R3: With the init enable (bit 6) set, `cnt_i == init_val_i` raises `trig_o` in the next cycle. With bit 6 clear, that equality has no effect.
- R4: Matches that coincide in one cycle give a single one-cycle pulse. Matches in consecutive cycles keep `trig_o` high in each of the following cycles.
- R5: The layout of the register word is as follows. Bit 7 is the flag and bit 6 is the init enable. Bit 4 enables channel 0 and bit 5 enables channel 1. Bits 0, 1, 2 and 3 enable channels 2, 3, 4 and 5. Every bit resets to 0. Any write loads bits 6:0 from `reg_wdata_i`, and reads return them.
- R6: Bits 31:8 always read as 0, whatever has been written to them.
- R7: Every trigger sets the flag. Writing 1 to bit 7 never sets the flag.
- R8: The flag clears only through a write with bit 7 at 0 that follows a read which returned bit 7 set. A write of 0 with no such read leaves the flag set. A read while the flag is clear does not arm the clear.
- R9: A trigger that happens after the arming read and before the clearing write cancels the sequence, and the flag stays set after that write.
- R10: When a trigger and an armed clearing write happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Current timer counter value |
| init_val_i | input | 16 | Counter initial (reload) value |
| cmp_val_i | input | 128 | Compare values, channel c at bits [16c+15:16c] |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume that a read strobe and a write strobe are never driven in the same cycle. They also assume that every input is stable and known while reset is low. Under those conditions the flag is never armed while it is clear, and the enables change only on a write. The stimulus obeys both assumptions: it chooses at most one strobe per cycle and drives every input at the falling edge. Counter, initial and compare values are drawn from a narrow range, so single and multiple matches, initial-value hits and near-miss cycles all occur often.

// File: rtl/trig_chan_pkg.sv
package trig_chan_pkg;

    localparam int REG_W       = 32;
    localparam int TRIG_CH     = 6;
    localparam int FLAG_BIT    = 7;
    localparam int INIT_EN_BIT = 6;
    localparam int USED_BITS   = 8;

    typedef struct packed {
        logic                 init_en;
        logic [TRIG_CH-1:0]   ch_en;
    } trig_cfg_t;

    typedef struct packed {
        logic             wr_en;
        logic             rd_en;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    // Register bits 5:0 to per-channel enables (channel index order).
    function automatic logic [TRIG_CH-1:0] field_to_en(input logic [5:0] f);
        logic [TRIG_CH-1:0] en;
        en[0]   = f[4];
        en[1]   = f[5];
        en[5:2] = f[3:0];
        return en;
    endfunction

    function automatic logic [5:0] en_to_field(input logic [TRIG_CH-1:0] en);
        logic [5:0] f;
        f[4]   = en[0];
        f[5]   = en[1];
        f[3:0] = en[5:2];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input trig_cfg_t cfg, input logic flag);
        logic [REG_W-1:0] w;
        w                = '0;
        w[FLAG_BIT]      = flag;
        w[INIT_EN_BIT]   = cfg.init_en;
        w[5:0]           = en_to_field(cfg.ch_en);
        return w;
    endfunction

endpackage

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_chan_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [CNT_W-1:0]         init_val_i,
    input  logic [NUM_CMP*CNT_W-1:0] cmp_val_i,
    input  trig_cfg_t                cfg_i,
    output logic                     hit_o,
    output logic                     trig_o
);

    logic [NUM_CMP-1:0] chan_eq;
    logic [NUM_CMP-1:0] chan_fire;
    logic               init_fire;
    logic               unused_eq_hi;
    logic               trig_q;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_chan
        assign chan_eq[i] = (cmp_val_i[i*CNT_W +: CNT_W] == cnt_i);
        if (i < TRIG_CH) begin : g_trig
            assign chan_fire[i] = chan_eq[i] & cfg_i.ch_en[i];
        end else begin : g_idle
            assign chan_fire[i] = 1'b0;
        end
    end

    assign unused_eq_hi = ^chan_eq;
    assign init_fire    = cfg_i.init_en & (cnt_i == init_val_i);
    assign hit_o        = init_fire | (|chan_fire);

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= hit_o;
    end

    assign trig_o = trig_q;

    AST_PULSE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        !hit_o |=> !trig_o); // R1

endmodule

// File: rtl/trig_flag_ctrl.sv
module trig_flag_ctrl
    import trig_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit_i,
    input  reg_req_t req_i,
    output logic     flag_o
);

    logic flag_q;
    logic armed_q;
    logic clr_ok;

    assign clr_ok = req_i.wr_en & armed_q & ~req_i.wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (hit_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (req_i.wr_en) begin
            if (clr_ok) flag_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (req_i.rd_en && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_SET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> flag_q); // R7

    AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !armed_q) |=> flag_q); // R8

    AST_ARMED_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> flag_q); // R9

endmodule

// File: rtl/trig_ctl_regs.sv
module trig_ctl_regs
    import trig_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req_i,
    input  logic             flag_i,
    output trig_cfg_t        cfg_o,
    output logic [REG_W-1:0] rdata_o
);

    trig_cfg_t cfg_q;
    logic      unused_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (req_i.wr_en) begin
            cfg_q.init_en <= req_i.wdata[INIT_EN_BIT];
            cfg_q.ch_en   <= field_to_en(req_i.wdata[5:0]);
        end
    end

    assign unused_wdata = ^{req_i.wdata[REG_W-1:USED_BITS], req_i.wdata[FLAG_BIT], req_i.rd_en};
    assign cfg_o        = cfg_q;
    assign rdata_o      = pack_word(cfg_q, flag_i);

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_i.wr_en |=> $stable(cfg_q)); // R5

endmodule

// File: rtl/trig_chan_gen.sv
module trig_chan_gen
    import trig_chan_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [CNT_W-1:0]         init_val_i,
    input  logic [NUM_CMP*CNT_W-1:0] cmp_val_i,
    input  logic                     reg_wr_en_i,
    input  logic                     reg_rd_en_i,
    input  logic [REG_W-1:0]         reg_wdata_i,
    output logic [REG_W-1:0]         reg_rdata_o,
    output logic                     trig_o
);

    reg_req_t  req;
    trig_cfg_t cfg;
    logic      hit;
    logic      flag;

    assign req = '{wr_en: reg_wr_en_i, rd_en: reg_rd_en_i, wdata: reg_wdata_i};

    trig_match_unit #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_match (
        .clk        (clk),
        .rst        (rst),
        .cnt_i      (cnt_i),
        .init_val_i (init_val_i),
        .cmp_val_i  (cmp_val_i),
        .cfg_i      (cfg),
        .hit_o      (hit),
        .trig_o     (trig_o)
    );

    trig_flag_ctrl u_flag (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .req_i  (req),
        .flag_o (flag)
    );

    trig_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .flag_i  (flag),
        .cfg_o   (cfg),
        .rdata_o (reg_rdata_o)
    );

    AST_TRIG_SETS_FLAG_PORT: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> reg_rdata_o[FLAG_BIT]); // R7

endmodule

// File: tb/tb_trig_chan_gen.sv
module tb_trig_chan_gen;

    localparam int CW = 16;
    localparam int NC = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [CW-1:0]  cnt, init_val;
    logic [NC*CW-1:0] cmp;
    logic           wr_en, rd_en;
    logic [31:0]    wdata;
    logic [31:0]    rdata;
    logic           trig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state
    logic [5:0] m_en;
    logic       m_init_en, m_flag, m_armed, m_trig;

    always #5 clk = ~clk;

    trig_chan_gen dut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .init_val_i(init_val), .cmp_val_i(cmp),
        .reg_wr_en_i(wr_en), .reg_rd_en_i(rd_en), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .trig_o(trig)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = 32'd0;
        w[7] = m_flag;
        w[6] = m_init_en;
        w[4] = m_en[0];
        w[5] = m_en[1];
        w[0] = m_en[2];
        w[1] = m_en[3];
        w[2] = m_en[4];
        w[3] = m_en[5];
        return w;
    endfunction

    function automatic logic [31:0] cfg_word(logic [5:0] en, logic ie);
        return {24'd0, 1'b0, ie, en[1], en[0], en[5], en[4], en[3], en[2]};
    endfunction

    function automatic logic exp_hit();
        logic h = m_init_en && (cnt == init_val);
        for (int c = 0; c < 6; c++)
            if (m_en[c] && cmp[c*CW +: CW] == cnt) h = 1'b1;
        return h;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // inputs already driven; advance one clock and compare
    task automatic step(string tag);
        logic h = exp_hit();
        if (h) begin
            m_flag = 1'b1; m_armed = 1'b0;
        end else if (wr_en) begin
            if (m_armed && !wdata[7]) m_flag = 1'b0;
            m_armed = 1'b0;
        end else if (rd_en && m_flag) begin
            m_armed = 1'b1;
        end
        if (wr_en) begin
            m_init_en = wdata[6];
            m_en = {wdata[3:0], wdata[5:4]};
        end
        m_trig = h;
        @(posedge clk);
        @(negedge clk);
        check({tag, " trig"}, {31'd0, trig}, {31'd0, m_trig});
        check({tag, " rdata"}, rdata, exp_word());
        wr_en = 0; rd_en = 0; wdata = '0;
    endtask

    task automatic quiet();
        cnt = 16'd100; init_val = 16'd300;
        for (int c = 0; c < NC; c++) cmp[c*CW +: CW] = 16'd200;
    endtask

    task automatic do_write(logic [31:0] d, string tag);
        wr_en = 1; wdata = d; step(tag);
    endtask

    task automatic do_read(string tag);
        rd_en = 1; step(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        process::self().srandom(32'h5eed_1234);
        rst = 1; wr_en = 0; rd_en = 0; wdata = '0; quiet();
        m_en = '0; m_init_en = 0; m_flag = 0; m_armed = 0; m_trig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R5 reset rdata", rdata, 32'd0);
        check("R1 reset trig", {31'd0, trig}, 32'd0);

        // R6/R7/R5: all ones written, flag stays clear, reserved zero
        do_write(32'hFFFF_FFFF, "R6 R7 write ones");
        check("R6 reserved bits", rdata & 32'hFFFF_FF00, 32'd0);
        check("R5 enables readback", rdata, 32'h0000_007F);
        // R5: individual channel bit mapping
        do_write(cfg_word(6'b000001, 0), "R5 ch0 maps bit4");
        check("R5 ch0 bit4", rdata, 32'h10);
        do_write(cfg_word(6'b100000, 0), "R5 ch5 maps bit3");
        check("R5 ch5 bit3", rdata, 32'h08);

        // R8: read with flag clear does not arm
        do_read("R8 read flag clear");
        // R2: high channels never trigger
        do_write(cfg_word(6'h3F, 1), "R2 enable all");
        cmp[6*CW +: CW] = cnt; cmp[7*CW +: CW] = cnt;
        step("R2 ch6 ch7 match");
        step("R2 ch6 ch7 match hold");
        quiet();
        // R1: channel 0 match gives one pulse
        cmp[0*CW +: CW] = cnt;
        step("R1 ch0 match");
        quiet();
        step("R1 pulse ends");
        // R8: write 0 without arming leaves flag
        do_write(cfg_word(6'h3F, 1), "R8 unarmed clear");
        check("R8 flag kept", {31'd0, rdata[7]}, 32'd1);
        // R8: proper sequence clears
        do_read("R8 arming read");
        do_write(cfg_word(6'h3F, 1), "R8 clearing write");
        check("R8 flag cleared", {31'd0, rdata[7]}, 32'd0);
        // R9: trigger between read and write cancels
        cmp[3*CW +: CW] = cnt; step("R9 trigger"); quiet();
        do_read("R9 arming read");
        cmp[5*CW +: CW] = cnt; step("R9 mid trigger"); quiet();
        do_write(cfg_word(6'h3F, 1), "R9 write after cancel");
        check("R9 flag kept", {31'd0, rdata[7]}, 32'd1);
        // R10: trigger with the clearing write
        do_read("R10 arming read");
        cmp[2*CW +: CW] = cnt;
        do_write(cfg_word(6'h3F, 1), "R10 same cycle");
        quiet();
        check("R10 flag kept", {31'd0, rdata[7]}, 32'd1);
        // R4: simultaneous and back-to-back matches
        cmp[0*CW +: CW] = cnt; cmp[1*CW +: CW] = cnt; init_val = cnt;
        step("R4 coincident");
        cnt = 16'd50; cmp[4*CW +: CW] = 16'd50; step("R4 consecutive");
        quiet(); step("R4 end");
        // R3: init trigger on and off
        do_write(cfg_word(6'h00, 1), "R3 init only");
        init_val = cnt; step("R3 init hit"); quiet();
        do_write(cfg_word(6'h00, 0), "R3 init off");
        init_val = cnt; step("R3 init disabled"); quiet();

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int op = $urandom_range(0, 9);
            cnt = 16'($urandom_range(0, 7));
            init_val = 16'($urandom_range(0, 7));
            for (int c = 0; c < NC; c++) cmp[c*CW +: CW] = 16'($urandom_range(0, 9));
            if (op < 2) begin
                wr_en = 1; wdata = $urandom();
            end else if (op < 4) begin
                rd_en = 1;
            end
            step("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule